// File: doc/BRIEF.md
# IR Pulse-Distance Frame Transmitter

This block sends one infrared command frame. Marks are bursts of a square-wave carrier on the LED drive; the LED stays dark during spaces. A bit is coded by the length of the space that follows its mark. The frame carries a 28-bit payload: a 4-bit motor number in the upper bits and a 24-bit position below it. The block sends the bits in a fixed order, highest first.

A start strobe launches the frame. The block first listens for a fixed window. If the receiver-busy input is seen at any clock in that window, the frame is dropped and a one-cycle defer pulse is raised. Otherwise the block drives the receiver-enable output low. It then sends a long header pair, a shorter header pair, the 28 data bits and a closing mark with a guard pause. After the guard pause it raises receiver-enable again and pulses done.

All durations count carrier half-periods. One half-period is `HALF_CLKS` clock cycles on which `tick_en_i` is high. The default of 100 gives 12.5 µs at 8 MHz, which is a 40 kHz carrier. A low `tick_en_i` freezes all timing.

Top module: `ir_pd_frame_tx`

## Requirements
- R1: After reset, led_o=0, rx_en_o=1, busy_o=0, done_o=0 and defer_o=0.
- R2: In a mark, led_o is high for the first half-period and then changes level every half-period. Every mark length is even, so each mark ends low. In a space, led_o is low.
- R3: A frame opens with a listen window of 80 half-periods, with led_o low and rx_en_o high. If rx_busy_i is high on any clock edge in this window, the frame is dropped. On the next cycle busy_o=0 and defer_o=1 for one cycle, and rx_en_o stays high.
- R4: The first header is a 160 half-period mark and a 160 half-period space. The second header is an 80 half-period mark and an 80 half-period space.
- R5: Each data bit is a 20 half-period mark. It is followed by a 20 half-period space for a 0 or a 40 half-period space for a 1. Bits go out from payload_i[27] down to payload_i[0].
- R6: After the last data bit comes a 20 half-period mark and then a 60 half-period guard space.
- R7: rx_en_o is low from the first header mark to the end of the guard space. On the cycle it rises again, busy_o falls and done_o is high for exactly one cycle.
- R8: A clock with tick_en_i low advances no timing. Each half-period takes exactly HALF_CLKS clocks with tick_en_i high.
- R9: start_i is ignored while busy_o is high, and the payload is captured only at the start. rx_busy_i has no effect after the listen window.
- R10: A complete frame occupies 1760 + 20·(number of ones in the payload) half-periods, counted from the cycle after the start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Timing enable; a clock with this low does not count |
| start_i | input | 1 | Start strobe, accepted only when idle |
| payload_i | input | 28 | Motor number [27:24] and position [23:0] |
| rx_busy_i | input | 1 | Receiver activity seen |
| led_o | output | 1 | LED drive |
| rx_en_o | output | 1 | Receiver enable |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |
| defer_o | output | 1 | One-cycle pulse when the listen window sees activity |

## Verification
A bad phase counter or a space length taken from the wrong bit changes the LED envelope within one segment. The bench compares led_o with its own model at every clock, so such a fault shows up within a few hundred half-periods. A prescaler that counts while tick_en_i is low shortens a half-period, and that shows at the first mark edge. A receiver-enable that rises too early, or a lost done pulse, shows at the guard end. The bench also counts the frame length, so an extra or missing bit shows there.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
   localparam int unsigned FRAME_PHASES = 32;
   localparam int unsigned PAYLOAD_W    = 28;
   localparam int unsigned PH_LISTEN    = 32;
   localparam int unsigned PH_HDR_LONG  = 31;
   localparam int unsigned PH_HDR_SHORT = 30;
   localparam int unsigned PH_CLOSE     = 1;
   localparam int unsigned PHASE_W      = 6;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/ir_tx_prescale.sv
module ir_tx_prescale #(
   parameter int unsigned HALF_CLKS = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic tick_en_i,
   output logic hp_tick_o
);
   localparam int unsigned PRE_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
   localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(HALF_CLKS - 1);

   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pre_q <= '0;
      else if (clr_i)          pre_q <= '0;
      else if (tick_en_i)      pre_q <= (pre_q == PRE_TOP) ? '0 : pre_q + 1'b1;
   end

   assign hp_tick_o = tick_en_i && (pre_q == PRE_TOP);

   p_pre_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/ir_tx_seq.sv
module ir_tx_seq
   import ir_tx_pkg::*;
#(
   parameter int unsigned LISTEN_HP    = 80,
   parameter int unsigned HL_MARK_HP   = 160,
   parameter int unsigned HL_SPACE_HP  = 160,
   parameter int unsigned HS_MARK_HP   = 80,
   parameter int unsigned HS_SPACE_HP  = 80,
   parameter int unsigned BIT_MARK_HP  = 20,
   parameter int unsigned ZERO_SPC_HP  = 20,
   parameter int unsigned ONE_SPC_HP   = 40,
   parameter int unsigned GUARD_HP     = 60,
   parameter int unsigned SEG_W        = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [PAYLOAD_W-1:0] payload_i,
   input  logic                 rx_busy_i,
   input  logic                 hp_tick_i,
   output logic                 launch_o,
   output logic                 busy_o,
   output logic                 listen_o,
   output logic                 in_mark_o,
   output logic [SEG_W-1:0]     seg_o,
   output logic                 done_o,
   output logic                 defer_o
);
   logic                 busy_q, mark_q, done_q, defer_q;
   logic [PHASE_W-1:0]   phase_q, phase_nx;
   logic [SEG_W-1:0]     seg_q, space_len, mark_len;
   logic [PAYLOAD_W-1:0] sh_q;
   logic                 listening, data_phase;

   assign listening  = busy_q && (phase_q == PHASE_W'(PH_LISTEN));
   assign data_phase = (phase_q < PHASE_W'(PH_HDR_SHORT)) && (phase_q > PHASE_W'(PH_CLOSE));
   assign phase_nx   = phase_q - 1'b1;
   assign launch_o   = !busy_q && start_i;

   always_comb begin
      if (phase_q == PHASE_W'(PH_HDR_LONG))       space_len = SEG_W'(HL_SPACE_HP);
      else if (phase_q == PHASE_W'(PH_HDR_SHORT)) space_len = SEG_W'(HS_SPACE_HP);
      else if (phase_q == PHASE_W'(PH_CLOSE))     space_len = SEG_W'(GUARD_HP);
      else if (sh_q[PAYLOAD_W-1])                 space_len = SEG_W'(ONE_SPC_HP);
      else                                        space_len = SEG_W'(ZERO_SPC_HP);
   end

   always_comb begin
      if (phase_nx == PHASE_W'(PH_HDR_LONG))       mark_len = SEG_W'(HL_MARK_HP);
      else if (phase_nx == PHASE_W'(PH_HDR_SHORT)) mark_len = SEG_W'(HS_MARK_HP);
      else                                         mark_len = SEG_W'(BIT_MARK_HP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         mark_q  <= 1'b0;
         done_q  <= 1'b0;
         defer_q <= 1'b0;
         phase_q <= '0;
         seg_q   <= '0;
         sh_q    <= '0;
      end else begin
         done_q  <= 1'b0;
         defer_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               busy_q  <= 1'b1;
               phase_q <= PHASE_W'(FRAME_PHASES);
               mark_q  <= 1'b0;
               seg_q   <= SEG_W'(LISTEN_HP);
               sh_q    <= payload_i;
            end
         end else if (listening && rx_busy_i) begin
            busy_q  <= 1'b0;
            defer_q <= 1'b1;
         end else if (hp_tick_i) begin
            if (seg_q != SEG_W'(1)) begin
               seg_q <= seg_q - 1'b1;
            end else if (mark_q) begin
               mark_q <= 1'b0;
               seg_q  <= space_len;
               if (data_phase) sh_q <= {sh_q[PAYLOAD_W-2:0], 1'b0};
            end else if (phase_q == PHASE_W'(PH_CLOSE)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               phase_q <= phase_nx;
               mark_q  <= 1'b1;
               seg_q   <= mark_len;
            end
         end
      end
   end

   assign busy_o    = busy_q;
   assign listen_o  = listening;
   assign in_mark_o = mark_q;
   assign seg_o     = seg_q;
   assign done_o    = done_q;
   assign defer_o   = defer_q;

   p_phase_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (phase_q >= PHASE_W'(PH_CLOSE)) && (phase_q <= PHASE_W'(PH_LISTEN)));
   p_phase_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> (phase_q <= $past(phase_q)));
   p_listen_no_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
      listening |-> !mark_q);
   p_seg_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (seg_q != '0));
endmodule

// File: rtl/ir_pd_frame_tx.sv
module ir_pd_frame_tx
   import ir_tx_pkg::*;
#(
   parameter int unsigned HALF_CLKS    = 100,
   parameter int unsigned LISTEN_HP    = 80,
   parameter int unsigned HL_MARK_HP   = 160,
   parameter int unsigned HL_SPACE_HP  = 160,
   parameter int unsigned HS_MARK_HP   = 80,
   parameter int unsigned HS_SPACE_HP  = 80,
   parameter int unsigned BIT_MARK_HP  = 20,
   parameter int unsigned ZERO_SPC_HP  = 20,
   parameter int unsigned ONE_SPC_HP   = 40,
   parameter int unsigned GUARD_HP     = 60
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_en_i,
   input  logic        start_i,
   input  logic [27:0] payload_i,
   input  logic        rx_busy_i,
   output logic        led_o,
   output logic        rx_en_o,
   output logic        busy_o,
   output logic        done_o,
   output logic        defer_o
);
   localparam int unsigned MAX_HP = max2(max2(max2(LISTEN_HP, HL_MARK_HP), max2(HL_SPACE_HP, HS_MARK_HP)),
                                         max2(max2(HS_SPACE_HP, ONE_SPC_HP), max2(GUARD_HP, ZERO_SPC_HP)));
   localparam int unsigned SEG_W  = $clog2(MAX_HP + 1);

   if (HALF_CLKS < 1) begin : g_bad_half
      $error("HALF_CLKS must be at least 1");
   end
   if ((HL_MARK_HP % 2) || (HS_MARK_HP % 2) || (BIT_MARK_HP % 2) || (BIT_MARK_HP == 0)) begin : g_bad_mark
      $error("mark lengths must be even and non-zero");
   end
   if ((LISTEN_HP == 0) || (GUARD_HP == 0) || (ZERO_SPC_HP == 0) || (ONE_SPC_HP <= ZERO_SPC_HP)) begin : g_bad_space
      $error("space lengths must be non-zero and a one longer than a zero");
   end

   logic             hp_tick, launch, busy, listen, in_mark;
   logic [SEG_W-1:0] seg;

   ir_tx_prescale #(.HALF_CLKS(HALF_CLKS)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr_i(launch), .tick_en_i(tick_en_i), .hp_tick_o(hp_tick));

   ir_tx_seq #(
      .LISTEN_HP(LISTEN_HP), .HL_MARK_HP(HL_MARK_HP), .HL_SPACE_HP(HL_SPACE_HP),
      .HS_MARK_HP(HS_MARK_HP), .HS_SPACE_HP(HS_SPACE_HP), .BIT_MARK_HP(BIT_MARK_HP),
      .ZERO_SPC_HP(ZERO_SPC_HP), .ONE_SPC_HP(ONE_SPC_HP), .GUARD_HP(GUARD_HP), .SEG_W(SEG_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .payload_i(payload_i),
      .rx_busy_i(rx_busy_i), .hp_tick_i(hp_tick), .launch_o(launch), .busy_o(busy),
      .listen_o(listen), .in_mark_o(in_mark), .seg_o(seg), .done_o(done_o), .defer_o(defer_o));

   assign led_o   = in_mark && !seg[0];
   assign rx_en_o = !(busy && !listen);
   assign busy_o  = busy;

   p_led_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_mark && hp_tick && (seg != SEG_W'(1))) |=> (led_o != $past(led_o)));
   p_rx_off_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en_o |-> busy_o);
   p_done_at_rx_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (rx_en_o && !busy_o && $past(!rx_en_o)));
   p_defer_from_listen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      defer_o |-> (rx_en_o && !busy_o && $past(listen)));
   p_frozen_led_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !listen && !tick_en_i) |=> $stable(led_o));
endmodule

// File: tb/ir_pd_frame_tx_bench.sv
`timescale 1ns/1ps
module ir_pd_frame_tx_bench;
   localparam int HALF = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b1;
   logic        start = 1'b0;
   logic [27:0] payload = '0;
   logic        rx_busy = 1'b0;
   logic        led, rx_en, busy, done, defer;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   ir_pd_frame_tx #(.HALF_CLKS(HALF)) u_ir_pd_frame_tx (
      .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en), .start_i(start), .payload_i(payload),
      .rx_busy_i(rx_busy), .led_o(led), .rx_en_o(rx_en), .busy_o(busy), .done_o(done),
      .defer_o(defer));

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // segment table from R3..R6: 0 listen, odd index = mark
   function automatic int seg_len(input int idx, input logic [27:0] p);
      if (idx == 0) return 80;
      if (idx == 1 || idx == 2) return 160;
      if (idx == 3 || idx == 4) return 80;
      if (idx == 61) return 20;
      if (idx == 62) return 60;
      if (idx % 2) return 20;
      return p[27 - (idx - 6) / 2] ? 40 : 20;
   endfunction

   function automatic int frame_hp(input logic [27:0] p);
      return 1760 + 20 * $countones(p);
   endfunction

   task automatic run_frame(input logic [27:0] p, input bit rnd_tick, input bit noise, input bit restart);
      int led_bad = 0, rx_bad = 0, st_bad = 0, en_cnt = 0;
      @(negedge clk);
      payload = p;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      payload = ~p;
      for (int s = 0; s < 63; s++) begin
         for (int j = 0; j < seg_len(s, p); j++) begin
            int k = 0;
            while (k < HALF) begin
               bit exp_led = (s % 2 == 1) && (j % 2 == 0);
               bit exp_rx  = (s == 0);
               bit te;
               if (led !== exp_led) begin
                  if (led_bad == 0)
                     $display("FAIL R2/R5 led seg %0d hp %0d: actual %b expected %b", s, j, led, exp_led);
                  led_bad++;
               end
               if (rx_en !== exp_rx) begin
                  if (rx_bad == 0)
                     $display("FAIL R7 rx_en seg %0d: actual %b expected %b", s, rx_en, exp_rx);
                  rx_bad++;
               end
               if (busy !== 1'b1 || done !== 1'b0 || defer !== 1'b0) begin
                  if (st_bad == 0)
                     $display("FAIL R9 status seg %0d: actual busy %b done %b expected 1 0", s, busy, done);
                  st_bad++;
               end
               te = rnd_tick ? 1'($urandom % 2) : 1'b1;
               tick_en = te;
               if (busy === 1'b1 && te) en_cnt++;
               rx_busy = (noise && s > 0) ? 1'($urandom % 2) : 1'b0;
               start   = restart && s == 5 && j == 0 && k == 0;
               if (te) k++;
               @(negedge clk);
            end
         end
      end
      start = 1'b0;
      check(led_bad == 0, "R2", "led mismatches", led_bad, 0);
      check(rx_bad == 0, "R7", "rx_en mismatches", rx_bad, 0);
      check(st_bad == 0, "R9", "status mismatches", st_bad, 0);
      check(done === 1'b1 && busy === 1'b0 && rx_en === 1'b1, "R7", "done at end", int'(done), 1);
      check(en_cnt == frame_hp(p) * HALF, "R10", "enabled clocks in frame", en_cnt, frame_hp(p) * HALF);
      rx_busy = 1'b0;
      tick_en = 1'b1;
      @(negedge clk);
      check(done === 1'b0 && led === 1'b0, "R7", "done one cycle", int'(done), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(led === 1'b0, "R1", "led after reset", int'(led), 0);
      check(rx_en === 1'b1, "R1", "rx_en after reset", int'(rx_en), 1);
      check(busy === 1'b0 && done === 1'b0 && defer === 1'b0, "R1", "status after reset", int'(busy), 0);

      // R4 R5 R6 directed payloads
      run_frame(28'h0000000, 1'b0, 1'b0, 1'b0);
      run_frame(28'hFFFFFFF, 1'b0, 1'b0, 1'b0);
      run_frame(28'h8000001, 1'b0, 1'b0, 1'b0);
      // R8 random tick gating
      run_frame(28'($urandom), 1'b1, 1'b0, 1'b0);
      // R9 noise after listen and a start strobe mid-frame
      run_frame(28'($urandom), 1'b0, 1'b1, 1'b1);
      run_frame(28'($urandom), 1'b1, 1'b1, 1'b0);

      // R3 activity during the listen window
      @(negedge clk);
      payload = 28'h5A5A5A5;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (7) @(negedge clk);
      check(busy === 1'b1 && rx_en === 1'b1, "R3", "listening rx_en", int'(rx_en), 1);
      rx_busy = 1'b1;
      @(negedge clk);
      rx_busy = 1'b0;
      check(busy === 1'b0 && defer === 1'b1, "R3", "defer pulse", int'(defer), 1);
      check(rx_en === 1'b1 && led === 1'b0, "R3", "rx_en after defer", int'(rx_en), 1);
      @(negedge clk);
      check(defer === 1'b0 && done === 1'b0, "R3", "defer one cycle", int'(defer), 0);
      repeat (400) @(negedge clk);
      check(led === 1'b0 && busy === 1'b0, "R3", "no frame after defer", int'(busy), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule